// File: doc/BRIEF.md
# Receive Message Queue with Host Release

This block holds received CAN frames in a 64-byte circular store and shows the oldest complete frame to a host through a fixed read window. A frame source pushes one byte per cycle. The first byte describes the frame, and the identifier and data bytes follow it. The block works out the frame length from that first byte. It commits the frame only once the last byte has arrived. If the frame cannot fit in the free space, the whole frame is dropped and an overrun flag is raised.

The host works through a small synchronous register port. Reads take effect in the same cycle and have no side effects. The host reads the window, then writes a release command, and the next stored frame moves into the window. The host can also read the number of stored frames, the start pointer of the oldest frame, a buffer-status bit and the overrun flag. A receive interrupt follows the buffer status while it is enabled.

Top module: `rx_msg_fifo`

## Requirements
- R1: Frame length is 1 + 2 bytes for a standard frame, or 1 + 4 bytes for an extended frame, plus the data bytes. The data byte count is min(DLC, 8) for a data frame and 0 for a remote frame. In the first byte, bit 7 = 1 marks extended, bit 6 = 1 marks remote, and bits 3:0 hold the DLC. Storage is 64 bytes, and all pointers wrap modulo 64.
- R2: Reading address 0x10+k (k = 0..12) returns byte k of the oldest stored frame, counted from its first byte.
- R3: Status (address 0x01) bit 0 reads 1 when at least one complete frame is stored, starting in the cycle after the frame's last byte. It reads 0 when no frame is stored.
- R4: Writing address 0x00 with bit 0 set releases the oldest frame. If frames remain, status bit 0 reads 0 for exactly one cycle after the release and then reads 1.
- R5: Output irq equals control (address 0x02) bit 0 AND status bit 0, so it drops when no frame remains.
- R6: Address 0x03 reads the stored frame count. Address 0x04 reads the start pointer, which advances by the released frame's length modulo 64 on each release.
- R7: A frame longer than the free space sets status bit 1 (overrun). The flag holds until address 0x00 is written with bit 1 set.
- R8: Reading the command address 0x00 returns 0xFF.
- R9: A dropped frame changes neither the frame count, the start pointer nor the stored frames. A later frame that fits is still accepted.
- R10: A release while no frame is stored has no effect on the count or the start pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fw_valid | input | 1 | Frame byte valid |
| fw_data | input | 8 | Frame byte; the first byte of each frame is the descriptor byte |
| reg_addr | input | 5 | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational from reg_addr) |
| irq | output | 1 | Receive interrupt |

## Verification
The embedded assertions check the following on every cycle:
- The byte occupancy never exceeds the storage size.
- An empty queue never shows full status or an interrupt.
- The start pointer moves only on a real release.
- A release that leaves frames behind always causes a one-cycle gap in the status bit.
- The overrun flag holds until it is cleared.
- A dropped frame leaves the frame count untouched.

Only the bench scenarios can show that the window returns the right bytes across wrap-around for every descriptor pattern, that lengths come out right for all DLC values, and that a frame that fits is accepted right after one was dropped.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    IN_IDLE    = 2'd0,
    IN_STORE   = 2'd1,
    IN_DISCARD = 2'd2
  } intake_state_t;

  localparam logic [4:0] CMD_ADDR   = 5'h00;
  localparam logic [4:0] STAT_ADDR  = 5'h01;
  localparam logic [4:0] CTRL_ADDR  = 5'h02;
  localparam logic [4:0] COUNT_ADDR = 5'h03;
  localparam logic [4:0] START_ADDR = 5'h04;
  localparam int unsigned WIN_LEN   = 13;

  // Total stored length of a frame, derived from its descriptor byte.
  function automatic logic [4:0] frame_len(input logic [7:0] desc);
    logic [3:0] nd;
    nd = (desc[3:0] > 4'd8) ? 4'd8 : desc[3:0];
    if (desc[6]) nd = 4'd0;
    return 5'd1 + (desc[7] ? 5'd4 : 5'd2) + {1'b0, nd};
  endfunction

endpackage

// File: rtl/rxf_ram.sv
module rxf_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/rxf_intake.sv
module rxf_intake
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_valid,
  input  logic [7:0]        fw_data,
  input  logic [ADDR_W:0]   free_bytes,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic              commit,
  output logic [4:0]        commit_len,
  output logic              drop
);
  localparam int unsigned FW = ADDR_W + 1;

  intake_state_t     state_q, state_n;
  logic [ADDR_W-1:0] wp_q, wp_n;
  logic [ADDR_W-1:0] wcur_q, wcur_n;
  logic [4:0]        rem_q, rem_n;
  logic [4:0]        len_q, len_n;
  logic [4:0]        new_len;
  logic              upd;

  always_comb begin
    state_n    = state_q;
    wp_n       = wp_q;
    wcur_n     = wcur_q;
    rem_n      = rem_q;
    len_n      = len_q;
    ram_we     = 1'b0;
    ram_waddr  = wcur_q;
    ram_wdata  = fw_data;
    commit     = 1'b0;
    commit_len = len_q;
    drop       = 1'b0;
    new_len    = frame_len(fw_data);
    if (fw_valid) begin
      unique case (state_q)
        IN_IDLE: begin
          rem_n = new_len - 5'd1;
          if (FW'(new_len) <= free_bytes) begin
            ram_we    = 1'b1;
            ram_waddr = wp_q;
            wcur_n    = wp_q + 1'b1;
            len_n     = new_len;
            state_n   = IN_STORE;
          end else begin
            drop    = 1'b1;
            state_n = IN_DISCARD;
          end
        end
        IN_STORE: begin
          ram_we = 1'b1;
          wcur_n = wcur_q + 1'b1;
          rem_n  = rem_q - 5'd1;
          if (rem_q == 5'd1) begin
            commit  = 1'b1;
            wp_n    = wcur_q + 1'b1;
            state_n = IN_IDLE;
          end
        end
        default: begin
          rem_n = rem_q - 5'd1;
          if (rem_q == 5'd1) state_n = IN_IDLE;
        end
      endcase
    end
  end

  assign upd = fw_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IN_IDLE;
      wp_q    <= '0;
      wcur_q  <= '0;
      rem_q   <= '0;
      len_q   <= '0;
    end else if (upd) begin
      state_q <= state_n;
      wp_q    <= wp_n;
      wcur_q  <= wcur_n;
      rem_q   <= rem_n;
      len_q   <= len_n;
    end
  end

  AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IN_DISCARD) |-> !commit) else $error("discarded frame committed"); // R9
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fw_valid,
  input  logic [7:0] fw_data,
  input  logic [4:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned CW    = ADDR_W + 1;

  logic [ADDR_W-1:0] rd_ptr_q, rd_ptr_n;
  logic [CW-1:0]     used_q, used_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              ovr_q, ovr_n;
  logic              gap_q, gap_n;
  logic              ien_q, ien_n;

  logic              ram_we, commit, drop;
  logic [ADDR_W-1:0] ram_waddr, win_addr;
  logic [7:0]        ram_wdata, win_data, head_desc;
  logic [4:0]        commit_len, rel_len;
  logic [CW-1:0]     free_bytes;
  logic              cmd_wr, rel_req, rel_ok, clr_ovr, rx_full, win_hit;

  assign free_bytes = CW'(DEPTH) - used_q;

  rxf_intake #(.ADDR_W(ADDR_W)) intake_i (
    .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_data(fw_data),
    .free_bytes(free_bytes), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .commit(commit), .commit_len(commit_len), .drop(drop)
  );

  rxf_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr_a(win_addr), .rdata_a(win_data),
    .raddr_b(rd_ptr_q), .rdata_b(head_desc)
  );

  assign cmd_wr  = reg_wr && (reg_addr == CMD_ADDR);
  assign rel_req = cmd_wr && reg_wdata[0];
  assign rel_ok  = rel_req && (cnt_q != '0);
  assign clr_ovr = cmd_wr && reg_wdata[1];
  assign rel_len = frame_len(head_desc);

  always_comb begin
    used_n   = used_q + (commit ? CW'(commit_len) : '0) - (rel_ok ? CW'(rel_len) : '0);
    cnt_n    = cnt_q + (commit ? CW'(1) : '0) - (rel_ok ? CW'(1) : '0);
    rd_ptr_n = rel_ok ? rd_ptr_q + ADDR_W'(rel_len) : rd_ptr_q;
    gap_n    = rel_ok && (cnt_n != '0);
    ovr_n    = drop ? 1'b1 : (clr_ovr ? 1'b0 : ovr_q);
    ien_n    = (reg_wr && (reg_addr == CTRL_ADDR)) ? reg_wdata[0] : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      used_q   <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
      gap_q    <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      if (commit || rel_ok) begin
        used_q <= used_n;
        cnt_q  <= cnt_n;
      end
      if (rel_ok) rd_ptr_q <= rd_ptr_n;
      if (drop || clr_ovr) ovr_q <= ovr_n;
      if (reg_wr) ien_q <= ien_n;
      gap_q <= gap_n;
    end
  end

  assign rx_full = (cnt_q != '0) && !gap_q;
  assign irq     = ien_q && rx_full;

  assign win_hit  = reg_addr[4] && (32'(reg_addr[3:0]) < WIN_LEN);
  assign win_addr = rd_ptr_q + ADDR_W'(reg_addr[3:0]);

  always_comb begin
    if (win_hit) reg_rdata = win_data;
    else begin
      unique case (reg_addr)
        CMD_ADDR:   reg_rdata = 8'hFF;
        STAT_ADDR:  reg_rdata = {6'd0, ovr_q, rx_full};
        CTRL_ADDR:  reg_rdata = {7'd0, ien_q};
        COUNT_ADDR: reg_rdata = 8'(cnt_q);
        START_ADDR: reg_rdata = 8'(rd_ptr_q);
        default:    reg_rdata = 8'h00;
      endcase
    end
  end

  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= CW'(DEPTH)) else $error("occupancy above storage size"); // R1
  AST_EMPTY_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> ((reg_addr != STAT_ADDR) || !reg_rdata[0])) else $error("empty shows full"); // R3
  AST_EMPTY_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (used_q == '0)) else $error("bytes held with no frame"); // R1
  AST_GAP_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ok && (cnt_q > CW'(1))) |=> !rx_full) else $error("status not cleared after release"); // R4
  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !irq) else $error("irq with empty queue"); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_ok |=> $stable(rd_ptr_q)) else $error("start pointer moved without release"); // R6
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_ovr) |=> ovr_q) else $error("overrun flag lost"); // R7
  AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !rel_ok) |=> $stable(cnt_q)) else $error("dropped frame counted"); // R9
  AST_REL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && (cnt_q == '0)) |=> $stable(rd_ptr_q)) else $error("release on empty moved pointer"); // R10
endmodule

// File: tb/rx_msg_fifo_tb_top.sv
module rx_msg_fifo_tb_top;
  logic       clk;
  logic       rst_n;
  logic       fw_valid;
  logic [7:0] fw_data;
  logic [4:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks;
  int errors;
  bit done;
  int exp_ptr;

  rx_msg_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_data(fw_data),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_len(input logic [7:0] d);
    int nd;
    nd = (d[3:0] > 8) ? 8 : int'(d[3:0]);
    if (d[6]) nd = 0;
    return 1 + (d[7] ? 4 : 2) + nd;
  endfunction

  function automatic logic [7:0] gen(input int n, input int i);
    return 8'(n * 7 + i * 13 + 1);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_now(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] desc, input int n);
    int len;
    len = exp_len(desc);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      fw_valid = 1'b1;
      fw_data  = (i == 0) ? desc : gen(n, i);
    end
    @(negedge clk);
    fw_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] d;
    int len;
    int n;
    int cnt;
    checks = 0; errors = 0; done = 0; exp_ptr = 0;
    rst_n = 1'b0; fw_valid = 1'b0; fw_data = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    rd(5'h01, v); chk("R3 reset status", v, 8'h00);
    rd(5'h03, v); chk("R6 reset count", v, 8'h00);
    rd(5'h04, v); chk("R6 reset start", v, 8'h00);
    chk("R5 reset irq", {7'd0, irq}, 8'h00);
    rd(5'h00, v); chk("R8 command reads FF", v, 8'hFF);

    // Sweep of every descriptor shape, one frame at a time, wrapping pointer
    wr(5'h02, 8'h01);
    n = 0;
    for (int ext = 0; ext < 2; ext++)
      for (int rtr = 0; rtr < 2; rtr++)
        for (int dlc = 0; dlc < 16; dlc++) begin
          d = {1'(ext), 1'(rtr), 2'b00, 4'(dlc)};
          len = exp_len(d);
          push(d, n);
          rd_now(5'h03, v); chk("R3 count after frame", v, 8'h01);
          rd(5'h01, v); chk("R3 status full", v, 8'h01);
          chk("R5 irq full", {7'd0, irq}, 8'h01);
          rd(5'h04, v); chk("R6 start pointer", v, 8'(exp_ptr));
          rd(5'h10, v); chk("R2 window descriptor", v, d);
          for (int k = 1; k < len; k++) begin
            rd(5'(16 + k), v); chk("R1 R2 window byte", v, gen(n, k));
          end
          wr(5'h00, 8'h01);
          exp_ptr = (exp_ptr + len) % 64;
          rd_now(5'h01, v); chk("R3 status empty", v, 8'h00);
          chk("R5 irq empty", {7'd0, irq}, 8'h00);
          rd(5'h03, v); chk("R6 count after release", v, 8'h00);
          rd(5'h04, v); chk("R6 start advance", v, 8'(exp_ptr));
          n++;
        end

    // Fill: five 11-byte frames fit, the sixth is dropped
    for (int f = 0; f < 5; f++) push(8'h08, 100 + f);
    rd(5'h01, v); chk("R7 no overrun yet", v, 8'h01);
    push(8'h08, 105);
    rd_now(5'h01, v); chk("R7 overrun set", v, 8'h03);
    rd(5'h03, v); chk("R9 count after drop", v, 8'h05);
    rd(5'h04, v); chk("R9 start after drop", v, 8'(exp_ptr));
    push(8'h45, 106);
    rd_now(5'h03, v); chk("R9 fitting frame accepted", v, 8'h06);
    push(8'h08, 107);
    rd_now(5'h03, v); chk("R9 second drop count", v, 8'h06);
    rd(5'h01, v); chk("R7 overrun held", v, 8'h03);
    wr(5'h00, 8'h02);
    rd_now(5'h01, v); chk("R7 overrun cleared", v, 8'h01);
    rd(5'h03, v); chk("R7 clear keeps count", v, 8'h06);
    wr(5'h02, 8'h00);
    chk("R5 irq disabled", {7'd0, irq}, 8'h00);
    wr(5'h02, 8'h01);
    chk("R5 irq enabled", {7'd0, irq}, 8'h01);

    // Drain in order, checking the one-cycle status gap
    cnt = 6;
    for (int f = 0; f < 6; f++) begin
      n = (f < 5) ? 100 + f : 106;
      d = (f < 5) ? 8'h08 : 8'h45;
      rd(5'h10, v); chk("R2 drain descriptor", v, d);
      rd(5'h11, v); chk("R2 drain id byte", v, gen(n, 1));
      rd(5'h04, v); chk("R6 drain start", v, 8'(exp_ptr));
      wr(5'h00, 8'h01);
      exp_ptr = (exp_ptr + exp_len(d)) % 64;
      cnt--;
      rd_now(5'h01, v); chk("R4 status gap", v, 8'h00);
      rd(5'h01, v); chk("R4 status after gap", v, (cnt > 0) ? 8'h01 : 8'h00);
      rd(5'h03, v); chk("R6 drain count", v, 8'(cnt));
    end
    chk("R5 irq drops when empty", {7'd0, irq}, 8'h00);

    // Release on empty
    wr(5'h00, 8'h01);
    rd_now(5'h03, v); chk("R10 count unchanged", v, 8'h00);
    rd(5'h04, v); chk("R10 start unchanged", v, 8'(exp_ptr));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule